// File: doc/BRIEF.md
# Decimating Sample Formatter

This block conditions one 32-bit sample stream before it is packed into frames. A 5-bit select chooses the source each cycle: nothing, an internal test counter, or one of `N_CH` channel words, each with its own valid. The chosen word goes through sign extension from a programmable bit position, either across the full word or separately within each 16-bit half. A decimator then keeps one result per group of `D+1` source samples, where `D` is the divisor input.

When averaging is requested and the group size is a power of two, the block emits the mean of the group instead of its last sample. The mean is computed per 16-bit half in paired-sample mode. The result is registered and appears with a one-cycle valid pulse. It holds its value until the next result.

All configuration inputs are plain levels. The surrounding logic decodes them from its own register file.

Top module: `sample_formatter`

## Requirements
- R1: While `rst` is high at a clock edge, both `valid_o` and `data_o` are cleared. The group position and the test counter also return to zero.
- R2: A select of 0 produces no source samples. A select of `N_CH+2` or higher also produces none. In both cases `valid_o` stays low.
- R3: A select of k+2 (k < `N_CH`) takes channel k, which sits at `ch_data_i[32k+31:32k]`, qualified by `ch_valid_i[k]`.
- R4: A select of 1 takes the test counter as the sample, qualified by `ch_valid_i[0]`. The counter reads 0 after reset and steps by one after each such qualified cycle. It holds in all other cycles.
- R5: With averaging off, exactly one result is emitted per `div_i+1` source samples, and it is the last sample of the group. With `div_i` = 0, every sample is emitted.
- R6: `valid_o` rises in the cycle after the clock edge that accepted the group's last sample. `data_o` keeps its value whenever `valid_o` is low.
- R7: With averaging on and `div_i+1` a power of two, the result is the floor of the sum of the group's formatted samples divided by `div_i+1`. The sum is signed when `sign_en_i` is 1.
- R8: With averaging on and `div_i+1` not a power of two, the result is the last sample of the group, as in R5.
- R9: With `sign_en_i`=1 and `half_mode_i`=0, every bit above `sign_pos_i` is replaced by the bit at `sign_pos_i`, and the bits at and below it are kept. A position of 31 leaves the word unchanged.
- R10: With `sign_en_i`=1 and `half_mode_i`=1, bits [15:0] and [31:16] are each extended on their own at position `sign_pos_i[3:0]` within the half. `sign_pos_i[4]` has no effect.
- R11: With `sign_en_i`=0, the word passes unmodified and averaging treats the values as unsigned.
- R12: In paired mode, averaging runs on each 16-bit half independently, with no carry or borrow between halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_data_i | input | N_CH*32 | Channel words, channel k at bits [32k+31:32k] |
| ch_valid_i | input | N_CH | Per-channel sample valid |
| sel_i | input | 5 | Source select: 0 off, 1 test counter, k+2 channel k |
| div_i | input | DIV_W | Decimation divisor D (group of D+1 samples) |
| sign_pos_i | input | 5 | Sign bit position |
| half_mode_i | input | 1 | 1: two 16-bit samples per word, 0: one 32-bit sample |
| sign_en_i | input | 1 | 1: signed treatment with sign extension |
| avg_en_i | input | 1 | 1: average the group when its size is a power of two |
| data_o | output | 32 | Formatted, decimated result |
| valid_o | output | 1 | One-cycle pulse per result |

## Verification
Each result is due one cycle after the clock edge that accepts the last sample of its group, because the only register on the path is the output stage. The test counter and the group position take effect at the same edge at which they are stepped. The bench drives inputs a short time after each rising edge and evaluates its reference model on the rising edge. At the following falling edge, it compares both outputs against what the model predicts for that edge, so every cycle is checked at the exact cycle its result is due, including the cycles in which `data_o` must hold.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;
  localparam logic [4:0] SEL_OFF  = 5'd0;
  localparam logic [4:0] SEL_TEST = 5'd1;
  localparam logic [4:0] SEL_BASE = 5'd2;
endpackage

// File: rtl/sf_source.sv
module sf_source
  import sf_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH*W-1:0] ch_data_i,
  input  logic [N_CH-1:0] ch_valid_i,
  input  logic [4:0]      sel_i,
  output logic            src_valid_o,
  output logic [W-1:0]    src_word_o
);

  logic [W-1:0] tcnt_q;
  logic [W-1:0] lane_w [N_CH];
  logic         test_step;

  for (genvar g = 0; g < N_CH; g++) begin : g_lane
    assign lane_w[g] = ch_data_i[g*W +: W];
  end

  always_comb begin
    src_valid_o = 1'b0;
    src_word_o  = '0;
    if (sel_i == SEL_TEST) begin
      src_valid_o = ch_valid_i[0];
      src_word_o  = tcnt_q;
    end else begin
      for (int k = 0; k < N_CH; k++) begin
        if (sel_i == 5'(k) + SEL_BASE) begin
          src_valid_o = ch_valid_i[k];
          src_word_o  = lane_w[k];
        end
      end
    end
  end

  assign test_step = (sel_i == SEL_TEST) && ch_valid_i[0];

  always_ff @(posedge clk) begin
    if (rst) tcnt_q <= '0;
    else if (test_step) tcnt_q <= tcnt_q + 1'b1;
  end

  // R4
  tcnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !test_step |=> $stable(tcnt_q))
    else $error("test counter moved without a qualified test cycle");

  // R4
  tcnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (src_valid_o && sel_i == SEL_TEST) |=> (tcnt_q == $past(src_word_o) + 1'b1))
    else $error("test counter did not step by one");

endmodule

// File: rtl/sf_sign_ext.sv
module sf_sign_ext
  import sf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [4:0]        pos_i,
  input  logic              half_i,
  input  logic              en_i,
  output logic [WORD_W-1:0] word_o
);

  logic [3:0] hpos;
  assign hpos = pos_i[3:0];

  always_comb begin
    word_o = word_i;
    if (en_i) begin
      if (half_i) begin
        for (int i = 0; i < HALF_W; i++) begin
          if (i > int'(hpos)) begin
            word_o[i]          = word_i[hpos];
            word_o[HALF_W + i] = word_i[HALF_W + int'(hpos)];
          end
        end
      end else begin
        for (int i = 0; i < WORD_W; i++) begin
          if (i > int'(pos_i)) word_o[i] = word_i[pos_i];
        end
      end
    end
  end

endmodule

// File: rtl/sf_avg_lane.sv
module sf_avg_lane #(
  parameter int W     = 16,
  parameter int DIV_W = 16,
  parameter int SH_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            add_i,
  input  logic            first_i,
  input  logic            signed_i,
  input  logic [W-1:0]    sample_i,
  input  logic [SH_W-1:0] shift_i,
  output logic [W-1:0]    avg_o
);

  localparam int AW = W + DIV_W + 1;

  logic [AW-1:0]        acc_q;
  logic [AW-1:0]        ext;
  logic [AW-1:0]        total;
  logic signed [AW-1:0] total_s;
  logic signed [AW-1:0] sra;
  logic [AW-1:0]        srl;

  always_comb begin
    ext     = signed_i ? {{(AW-W){sample_i[W-1]}}, sample_i} : {{(AW-W){1'b0}}, sample_i};
    total   = (first_i ? '0 : acc_q) + ext;
    total_s = total;
    sra     = total_s >>> shift_i;
    srl     = total >> shift_i;
    avg_o   = signed_i ? sra[W-1:0] : srl[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (add_i) acc_q <= total;
  end

endmodule

// File: rtl/sample_formatter.sv
module sample_formatter
  import sf_pkg::*;
#(
  parameter int N_CH  = 4,
  parameter int DIV_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_CH*WORD_W-1:0] ch_data_i,
  input  logic [N_CH-1:0]        ch_valid_i,
  input  logic [4:0]             sel_i,
  input  logic [DIV_W-1:0]       div_i,
  input  logic [4:0]             sign_pos_i,
  input  logic                   half_mode_i,
  input  logic                   sign_en_i,
  input  logic                   avg_en_i,
  output logic [WORD_W-1:0]      data_o,
  output logic                   valid_o
);

  localparam int SH_W = $clog2(DIV_W + 1);

  logic              src_valid;
  logic [WORD_W-1:0] src_word;
  logic [WORD_W-1:0] fmt_word;
  logic [DIV_W-1:0]  grp_q;
  logic              grp_last;
  logic              grp_first;
  logic [DIV_W:0]    grp_n;
  logic              grp_pow2;
  logic [SH_W-1:0]   grp_sh;
  logic              use_avg;
  logic [WORD_W-1:0] avg_full;
  logic [HALF_W-1:0] avg_half [2];
  logic [WORD_W-1:0] avg_word;
  logic [WORD_W-1:0] keep_mask;

  sf_source #(.N_CH(N_CH), .W(WORD_W)) src_i (
    .clk        (clk),
    .rst        (rst),
    .ch_data_i  (ch_data_i),
    .ch_valid_i (ch_valid_i),
    .sel_i      (sel_i),
    .src_valid_o(src_valid),
    .src_word_o (src_word)
  );

  sf_sign_ext sext_i (
    .word_i(src_word),
    .pos_i (sign_pos_i),
    .half_i(half_mode_i),
    .en_i  (sign_en_i),
    .word_o(fmt_word)
  );

  // group size and its log2 when it is a power of two
  always_comb begin
    grp_n    = {1'b0, div_i} + 1'b1;
    grp_pow2 = (grp_n & (grp_n - 1'b1)) == '0;
    grp_sh   = '0;
    for (int i = 0; i <= DIV_W; i++) begin
      if (grp_n[i]) grp_sh = SH_W'(i);
    end
  end

  assign grp_last  = grp_q >= div_i;
  assign grp_first = grp_q == '0;
  assign use_avg   = avg_en_i && grp_pow2;

  sf_avg_lane #(.W(WORD_W), .DIV_W(DIV_W), .SH_W(SH_W)) avg_full_i (
    .clk     (clk),
    .rst     (rst),
    .add_i   (src_valid),
    .first_i (grp_first),
    .signed_i(sign_en_i),
    .sample_i(fmt_word),
    .shift_i (grp_sh),
    .avg_o   (avg_full)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    sf_avg_lane #(.W(HALF_W), .DIV_W(DIV_W), .SH_W(SH_W)) avg_half_i (
      .clk     (clk),
      .rst     (rst),
      .add_i   (src_valid),
      .first_i (grp_first),
      .signed_i(sign_en_i),
      .sample_i(fmt_word[h*HALF_W +: HALF_W]),
      .shift_i (grp_sh),
      .avg_o   (avg_half[h])
    );
  end

  assign avg_word = half_mode_i ? {avg_half[1], avg_half[0]} : avg_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q   <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= src_valid && grp_last;
      if (src_valid) begin
        grp_q <= grp_last ? '0 : grp_q + 1'b1;
        if (grp_last) data_o <= use_avg ? avg_word : fmt_word;
      end
    end
  end

  assign keep_mask = WORD_W'((33'd2 << sign_pos_i) - 33'd1);

  // R2
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i == SEL_OFF) |=> !valid_o)
    else $error("result emitted while source is off");

  // R5
  pass_all_chk: assert property (@(posedge clk) disable iff (rst)
    (src_valid && div_i == '0) |=> valid_o)
    else $error("undecimated sample not emitted");

  // R6
  src_cause_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(src_valid))
    else $error("result without a source sample one cycle earlier");

  // R6
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> $stable(data_o))
    else $error("data changed without a result");

  // R9
  low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (sign_en_i && !half_mode_i) |-> ((fmt_word ^ src_word) & keep_mask) == '0)
    else $error("sign extension disturbed bits at or below the position");

endmodule

// File: tb/sample_formatter_tb_top.sv
module sample_formatter_tb_top;
  localparam int N_CH  = 4;
  localparam int DIV_W = 16;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [N_CH*32-1:0]   ch_data_i = '0;
  logic [N_CH-1:0]      ch_valid_i = '0;
  logic [4:0]           sel_i = '0;
  logic [DIV_W-1:0]     div_i = '0;
  logic [4:0]           sign_pos_i = '0;
  logic                 half_mode_i = 1'b0;
  logic                 sign_en_i = 1'b0;
  logic                 avg_en_i = 1'b0;
  logic [31:0]          data_o;
  logic                 valid_o;

  always #5 clk = ~clk;

  sample_formatter #(.N_CH(N_CH), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .ch_data_i(ch_data_i), .ch_valid_i(ch_valid_i),
    .sel_i(sel_i), .div_i(div_i), .sign_pos_i(sign_pos_i),
    .half_mode_i(half_mode_i), .sign_en_i(sign_en_i), .avg_en_i(avg_en_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";
  logic [31:0] seed = 32'h1234_5678;

  // reference state
  logic        exp_v;
  logic [31:0] exp_d;
  logic [31:0] m_tcnt;
  int          m_gcnt;
  longint      sum_full, sum_lo, sum_hi;

  function automatic logic [31:0] ext_at(input logic [31:0] w, input int p, input int width);
    logic [31:0] r = w;
    for (int i = p + 1; i < width; i++) r[i] = w[p];
    return r;
  endfunction

  function automatic logic [31:0] fmt(input logic [31:0] w);
    logic [31:0] lo, hi;
    if (!sign_en_i) return w;
    if (!half_mode_i) return ext_at(w, int'(sign_pos_i), 32);
    lo = ext_at({16'h0, w[15:0]}, int'(sign_pos_i[3:0]), 16);
    hi = ext_at({16'h0, w[31:16]}, int'(sign_pos_i[3:0]), 16);
    return {hi[15:0], lo[15:0]};
  endfunction

  function automatic longint num16(input logic [15:0] x);
    return sign_en_i ? longint'($signed(x)) : longint'({48'h0, x});
  endfunction

  function automatic longint num32(input logic [31:0] x);
    return sign_en_i ? longint'($signed(x)) : longint'({32'h0, x});
  endfunction

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    logic        sv;
    logic [31:0] sw, f;
    longint      n, q, qlo, qhi;
    int          sh;
    bit          last;
    started = 1;
    if (rst) begin
      exp_v = 0; exp_d = 0; m_tcnt = 0; m_gcnt = 0;
      sum_full = 0; sum_lo = 0; sum_hi = 0;
    end else begin
      sv = 0; sw = 0;
      if (sel_i == 5'd1) begin
        sv = ch_valid_i[0]; sw = m_tcnt;
        if (sv) m_tcnt = m_tcnt + 1;
      end else if (sel_i >= 5'd2 && int'(sel_i) - 2 < N_CH) begin
        sv = ch_valid_i[int'(sel_i) - 2];
        sw = ch_data_i[(int'(sel_i) - 2) * 32 +: 32];
      end
      exp_v = 0;
      if (sv) begin
        f = fmt(sw);
        if (m_gcnt == 0) begin sum_full = 0; sum_lo = 0; sum_hi = 0; end
        sum_full += num32(f);
        sum_lo   += num16(f[15:0]);
        sum_hi   += num16(f[31:16]);
        last = m_gcnt >= int'(div_i);
        if (last) begin
          exp_v = 1;
          n = longint'(div_i) + 1;
          if (avg_en_i && ((n & (n - 1)) == 0)) begin
            sh = 0;
            while ((longint'(1) << sh) < n) sh++;
            q = sum_full >>> sh; qlo = sum_lo >>> sh; qhi = sum_hi >>> sh;
            exp_d = half_mode_i ? {qhi[15:0], qlo[15:0]} : q[31:0];
          end else begin
            exp_d = f;
          end
          m_gcnt = 0;
        end else begin
          m_gcnt++;
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (valid_o !== exp_v || data_o !== exp_d) begin
        fails++;
        $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                 cur_req, valid_o, data_o, exp_v, exp_d);
      end
    end
  end

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic cfg(input string req, input logic [4:0] s, input int d,
                     input logic [4:0] p, input bit h, input bit se, input bit av);
    cur_req = req;
    sel_i = s; div_i = DIV_W'(d); sign_pos_i = p;
    half_mode_i = h; sign_en_i = se; avg_en_i = av;
  endtask

  task automatic run(input int cycles, input bit sparse);
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk); #2;
      for (int k = 0; k < N_CH; k++) begin
        logic [31:0] r = lcg();
        ch_data_i[k*32 +: 32] = r;
        ch_valid_i[k] = sparse ? (r[7:6] != 2'b00) : 1'b1;
      end
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs cleared by reset
    checks++;
    if (valid_o !== 1'b0 || data_o !== 32'h0) begin
      fails++;
      $display("FAIL R1: valid=%0b data=%h expected 0 0", valid_o, data_o);
    end
    rst = 0;
    cfg("R3", 5'd2, 0, 5'd31, 0, 0, 0);  run(40, 1);   // R3 channel 0, R5 D=0
    cfg("R3", 5'd5, 0, 5'd31, 0, 0, 0);  run(30, 1);   // R3 last channel
    cfg("R2", 5'd0, 0, 5'd0, 0, 0, 0);   run(20, 0);   // R2 off
    cfg("R2", 5'd6, 0, 5'd0, 0, 0, 0);   run(20, 0);   // R2 beyond N_CH
    cfg("R2", 5'd31, 0, 5'd0, 0, 0, 0);  run(10, 0);   // R2 top code
    cfg("R4", 5'd1, 0, 5'd0, 0, 0, 0);   run(60, 1);   // R4 test counter
    cfg("R5", 5'd3, 3, 5'd31, 0, 0, 0);  run(60, 1);   // R5 R6 keep last of four
    cfg("R5", 5'd4, 6, 5'd31, 0, 0, 0);  run(60, 0);   // R5 group of seven
    cfg("R8", 5'd2, 2, 5'd31, 0, 0, 1);  run(60, 1);   // R8 avg on, size three
    cfg("R7", 5'd2, 3, 5'd31, 0, 1, 1);  run(80, 1);   // R7 signed mean of four
    cfg("R7", 5'd1, 15, 5'd31, 0, 1, 1); run(100, 0);  // R7 mean of sixteen
    cfg("R11", 5'd3, 3, 5'd7, 0, 0, 1);  run(80, 1);   // R11 unsigned mean
    cfg("R9", 5'd2, 0, 5'd7, 0, 1, 0);   run(40, 1);   // R9 position 7
    cfg("R9", 5'd2, 0, 5'd0, 0, 1, 0);   run(20, 0);   // R9 position 0
    cfg("R9", 5'd2, 0, 5'd31, 0, 1, 0);  run(20, 0);   // R9 position 31
    cfg("R10", 5'd3, 0, 5'd23, 1, 1, 0); run(40, 1);   // R10 bit 4 ignored
    cfg("R10", 5'd3, 0, 5'd15, 1, 1, 0); run(20, 0);   // R10 full half
    cfg("R12", 5'd4, 1, 5'd11, 1, 1, 1); run(60, 1);   // R12 signed halves
    cfg("R12", 5'd4, 3, 5'd15, 1, 0, 1); run(60, 1);   // R12 unsigned halves
    cfg("R6", 5'd2, 1, 5'd31, 0, 0, 0);  run(40, 1);   // R6 timing and hold
    @(posedge clk); #2;
    ch_valid_i = '0;
    run(4, 0);
    finish_up();
  end

endmodule